// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a core's load/store stage and a memory port that only handles aligned 32-bit words. It takes one request at a time: a byte, halfword or word access at any byte address, with a direction and write data. It breaks the request into a short run of naturally aligned sub-transfers. Each sub-transfer gets a word address, byte-lane strobes and lane-placed write data. For loads, it collects the returned bytes into one little-endian result and signals completion once.

Byte requests, and halfword or word requests already on their natural boundary, go out as a single transfer. A misaligned request costs one or two extra transfers, and every memory wait state stretches the sub-transfer it hits. On a store, the memory port is taken to be a posted write buffer. A store is finished when the buffer accepts its last piece, so the core never waits for the write to reach memory.

Top module: `misalign_splitter`

## Requirements
- R1: A byte request (req_size = 0) at any address produces exactly one transfer with a single strobe bit set, at lane addr[1:0].
- R2: A halfword request (req_size = 1) at an even address, or a word request (req_size = 2) at a multiple of four, produces exactly one transfer with no added cycle.
- R3: A halfword at an odd address is sent as two byte transfers, lower address first.
- R4: A word at an address equal to 2 modulo 4 is sent as two halfword transfers, lower address first.
- R5: A word at an odd address is sent as byte, halfword, byte, in ascending address order.
- R6: Every transfer drives a word-aligned mem_addr (bits 1:0 zero). Its strobe is one lane, lanes 1:0, lanes 3:2, or all four.
- R7: While mem_valid is high and mem_ready is low, mem_addr, mem_strb and mem_wdata hold steady. The time from acceptance to done is (pieces + wait cycles) clock cycles.
- R8: A load result is little-endian: the byte at the request address goes to rdata[7:0]. Bits above the access size read as zero.
- R9: Each store piece places request byte k, counted from the request address, on the bus lane that matches that byte's address.
- R10: done is high for exactly one cycle, in the cycle after the last piece is accepted. It is the same for loads and stores. req_ready is low from acceptance until done.
- R11: After reset, and whenever reset is asserted mid-access, req_ready is high and mem_valid, done and rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Store data, least significant byte at req_addr |
| req_ready | output | 1 | Idle, request accepted this cycle if valid |
| mem_valid | output | 1 | Sub-transfer on the bus |
| mem_write | output | 1 | Sub-transfer is a store |
| mem_addr | output | ADDR_W | Word-aligned transfer address |
| mem_strb | output | 4 | Active byte lanes |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_ready | input | 1 | Memory or write buffer accepts the transfer; low inserts a wait |
| mem_rdata | input | 32 | Read word, sampled when mem_ready is high |
| done | output | 1 | Access complete (one-cycle pulse) |
| rdata | output | 32 | Assembled load result, held until the next request |

## Verification
A wrong piece index or base offset shows up on the very next transfer. It appears as a strobe pattern or word address that differs from the greedy ascending split, or as write bytes landing in the wrong lane. A broken last-piece decision changes the transfer count, so done arrives a cycle early or late. A corrupted gather path shows only at done, as a misplaced or leftover byte in rdata. Wait states reveal any state that advances without mem_ready, because the address moves while the stall is still active.

// File: rtl/mas_pkg.sv
package mas_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // number of aligned pieces needed for an access
  function automatic logic [1:0] piece_count(acc_size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE: piece_count = 2'd1;
      SZ_HALF: piece_count = off[0] ? 2'd2 : 2'd1;
      default: begin
        if (off == 2'd0)      piece_count = 2'd1;
        else if (off == 2'd2) piece_count = 2'd2;
        else                  piece_count = 2'd3;
      end
    endcase
  endfunction

  // byte offset of piece idx within the access
  function automatic logic [1:0] piece_pos(acc_size_e sz, logic [1:0] off, logic [1:0] idx);
    case (sz)
      SZ_BYTE: piece_pos = 2'd0;
      SZ_HALF: piece_pos = off[0] ? idx : 2'd0;
      default: begin
        if (off == 2'd0)      piece_pos = 2'd0;
        else if (off == 2'd2) piece_pos = {idx[0], 1'b0};
        else                  piece_pos = (idx == 2'd2) ? 2'd3 : idx;
      end
    endcase
  endfunction

  // width in bytes of piece idx
  function automatic logic [2:0] piece_len(acc_size_e sz, logic [1:0] off, logic [1:0] idx);
    case (sz)
      SZ_BYTE: piece_len = 3'd1;
      SZ_HALF: piece_len = off[0] ? 3'd1 : 3'd2;
      default: begin
        if (off == 2'd0)      piece_len = 3'd4;
        else if (off == 2'd2) piece_len = 3'd2;
        else                  piece_len = (idx == 2'd1) ? 3'd2 : 3'd1;
      end
    endcase
  endfunction

endpackage

// File: rtl/mas_planner.sv
module mas_planner
  import mas_pkg::*;
(
  input  acc_size_e   size,
  input  logic [1:0]  off,
  input  logic [1:0]  idx,
  output logic [1:0]  pos,
  output logic [2:0]  len,
  output logic        last
);
  logic [1:0] cnt;

  always_comb begin
    cnt  = piece_count(size, off);
    pos  = piece_pos(size, off, idx);
    len  = piece_len(size, off, idx);
    last = (idx == cnt - 2'd1);
  end

  // a piece never runs past the end of the 4-byte access window
  always_comb begin
    AST_PIECE_IN_WORD: assert ((4'(pos) + 4'(len)) <= 4'd4); // R6
  end
endmodule

// File: rtl/mas_lanes.sv
module mas_lanes #(
  parameter int LANES = 4
) (
  input  logic [1:0]           lane_off,
  input  logic [1:0]           pos,
  input  logic [2:0]           len,
  input  logic [8*LANES-1:0]   wdata,
  output logic [LANES-1:0]     strb,
  output logic [8*LANES-1:0]   lane_wdata
);
  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic [1:0] rel;
    logic [1:0] src;
    logic       act;
    always_comb begin
      rel = 2'(L) - lane_off;
      act = (3'(rel) < len);
      src = pos + rel;
      strb[L] = act;
      lane_wdata[8*L +: 8] = act ? wdata[8*src +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/mas_gather.sv
module mas_gather #(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 capture,
  input  logic [1:0]           lane_off,
  input  logic [1:0]           pos,
  input  logic [2:0]           len,
  input  logic [8*LANES-1:0]   bus,
  output logic [8*LANES-1:0]   result
);
  for (genvar J = 0; J < LANES; J++) begin : g_byte
    logic [1:0] rel;
    logic [1:0] lane;
    logic       hit;
    always_comb begin
      rel  = 2'(J) - pos;
      hit  = (2'(J) >= pos) && (3'(rel) < len);
      lane = lane_off + rel;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              result[8*J +: 8] <= 8'h00;
      else if (clear)          result[8*J +: 8] <= 8'h00;
      else if (capture && hit) result[8*J +: 8] <= bus[8*lane +: 8];
    end
  end
endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
  import mas_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_strb,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic [31:0]       rdata
);
  localparam int LANES = 4;

  logic              busy;
  logic [1:0]        idx;
  logic [ADDR_W-1:0] r_addr;
  acc_size_e         r_size;
  logic              r_write;
  logic [31:0]       r_wdata;
  logic              done_q;

  logic [1:0]        pos;
  logic [2:0]        len;
  logic              last;
  logic [ADDR_W-1:0] piece_baddr;

  // named events
  logic accept, step_adv, step_fin;
  assign accept   = req_valid && !busy;
  assign step_adv = busy && mem_ready && !last;
  assign step_fin = busy && mem_ready && last;

  mas_planner u_plan (
    .size (r_size),
    .off  (r_addr[1:0]),
    .idx  (idx),
    .pos  (pos),
    .len  (len),
    .last (last)
  );

  assign piece_baddr = r_addr + ADDR_W'(pos);

  mas_lanes #(.LANES(LANES)) u_lanes (
    .lane_off   (piece_baddr[1:0]),
    .pos        (pos),
    .len        (len),
    .wdata      (r_wdata),
    .strb       (mem_strb),
    .lane_wdata (mem_wdata)
  );

  mas_gather #(.LANES(LANES)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .capture  (busy && mem_ready && !r_write),
    .lane_off (piece_baddr[1:0]),
    .pos      (pos),
    .len      (len),
    .bus      (mem_rdata),
    .result   (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= 2'd0;
      r_addr  <= '0;
      r_size  <= SZ_BYTE;
      r_write <= 1'b0;
      r_wdata <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= step_fin;
      if (accept) begin
        busy    <= 1'b1;
        idx     <= 2'd0;
        r_addr  <= req_addr;
        r_size  <= (req_size == 2'd3) ? SZ_WORD : acc_size_e'(req_size);
        r_write <= req_write;
        r_wdata <= req_wdata;
      end else if (step_fin) begin
        busy <= 1'b0;
        idx  <= 2'd0;
      end else if (step_adv) begin
        idx <= idx + 2'd1;
      end
    end
  end

  assign req_ready = !busy;
  assign mem_valid = busy;
  assign mem_write = busy && r_write;
  assign mem_addr  = {piece_baddr[ADDR_W-1:2], 2'b00};
  assign done      = done_q;

  AST_STRB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_strb inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                    4'b0011, 4'b1100, 4'b1111})); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_strb) && $stable(mem_wdata))); // R7
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    step_adv |=> (piece_baddr == $past(piece_baddr) + ADDR_W'($past(len)))); // R5
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_valid && mem_ready)); // R10
endmodule

// File: tb/sim_misalign_splitter.sv
module sim_misalign_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, mem_valid, mem_write, done;
  logic [31:0] mem_addr, mem_wdata, rdata;
  logic [3:0]  mem_strb;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] dmem [64];
  logic [7:0] rmem [64];

  always #5 clk = ~clk;

  misalign_splitter u0 (.*);

  localparam int NV = 15;
  localparam int          V_SZ [NV] = '{0,1,2,1,1,2,2,2,0,1,2,2,2,2,2};
  localparam int          V_AD [NV] = '{5,8,12,17,19,22,25,27,35,37,42,45,51,48,45};
  localparam bit          V_WR [NV] = '{0,0,0,0,0,0,0,0,1,1,1,1,1,1,0};
  localparam logic [31:0] V_WD [NV] = '{0,0,0,0,0,0,0,0,32'hA5,32'hBEEF,32'h11223344,
                                        32'hCAFEF00D,32'h76543210,32'h0BADF00D,0};
  localparam int          V_WT [NV] = '{0,0,0,0,1,0,0,2,0,1,0,0,2,0,1};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int nbytes(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  // largest naturally aligned chunk fitting at cur with rem bytes left
  function automatic int chunk(int cur, int rem);
    if (cur % 4 == 0 && rem >= 4) return 4;
    if (cur % 2 == 0 && rem >= 2) return 2;
    return 1;
  endfunction

  function automatic int count_pieces(int a, int n);
    int c = 0;
    while (n > 0) begin
      int w = chunk(a, n);
      a += w; n -= w; c++;
    end
    return c;
  endfunction

  function automatic string kind_tag(int sz, int a);
    if (sz == 0) return "R1";
    if ((sz == 1 && a % 2 == 0) || (sz == 2 && a % 4 == 0)) return "R2";
    if (sz == 1) return "R3";
    if (a % 4 == 2) return "R4";
    return "R5";
  endfunction

  task automatic run_op(input int sz, input int a, input bit wr,
                        input logic [31:0] wd, input int wt);
    int n = nbytes(sz), cur = a, rem = n, cycles = 0, xfers = 0, stall = 0;
    int exp_p = count_pieces(a, n);
    bit seq_ok = 1, lane_ok = 1, hold_ok = 1, busy_ok = 1, fin = 0;
    logic [31:0] exp_r = '0, h_addr = '0, h_wd = '0;
    logic [3:0] h_strb = '0;
    string tg = kind_tag(sz, a);
    for (int k = 0; k < n; k++) exp_r[8*k +: 8] = rmem[a + k];
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = 2'(sz); req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (cycles < 60) begin
      if (done) begin fin = 1; break; end
      if (mem_valid) begin
        int w = chunk(cur, rem);
        logic [3:0] es = 4'(((1 << w) - 1) << (cur % 4));
        if (req_ready) busy_ok = 0;
        if (mem_addr != 32'(cur & ~3) || mem_strb != es) seq_ok = 0;
        if (stall > 0 && (mem_addr != h_addr || mem_strb != h_strb || mem_wdata != h_wd))
          hold_ok = 0;
        if (wr) for (int L = 0; L < 4; L++)
          if (es[L] && mem_wdata[8*L +: 8] != wd[8*((cur - a) + L - cur % 4) +: 8])
            lane_ok = 0;
        mem_rdata = {dmem[(cur & ~3) + 3], dmem[(cur & ~3) + 2],
                     dmem[(cur & ~3) + 1], dmem[cur & ~3]};
        h_addr = mem_addr; h_strb = mem_strb; h_wd = mem_wdata;
        if (stall < wt) begin
          mem_ready = 0; stall++;
        end else begin
          mem_ready = 1; stall = 0;
          if (wr) for (int L = 0; L < 4; L++)
            if (mem_strb[L]) dmem[(cur & ~3) + L] = mem_wdata[8*L +: 8];
          cur += w; rem -= w; xfers++;
        end
      end else mem_ready = 0;
      @(posedge clk);
      cycles++;
      @(negedge clk);
    end
    mem_ready = 0;
    chk(fin, "R10", "done seen", 32'(fin), 1);
    chk(xfers == exp_p, tg, "transfer count", xfers, exp_p);
    chk(seq_ok, "R6", "address/strobe sequence", 32'(seq_ok), 1);
    chk(cycles == exp_p * (1 + wt), "R7", "latency", cycles, exp_p * (1 + wt));
    if (wt > 0) chk(hold_ok, "R7", "held during wait", 32'(hold_ok), 1);
    chk(busy_ok, "R10", "req_ready low while busy", 32'(busy_ok), 1);
    if (wr) begin
      bit same = 1;
      for (int k = 0; k < n; k++) rmem[a + k] = wd[8*k +: 8];
      for (int k = 0; k < 64; k++) if (dmem[k] != rmem[k]) same = 0;
      chk(lane_ok, "R9", "store lanes", 32'(lane_ok), 1);
      chk(same, "R9", "memory after store", 32'(same), 1);
    end else begin
      chk(rdata == exp_r, "R8", "load result", rdata, exp_r);
    end
    @(negedge clk);
    chk(!done, "R10", "done single cycle", 32'(done), 0);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) begin
      dmem[k] = 8'(8'h10 + 7 * k);
      rmem[k] = dmem[k];
    end
    repeat (2) @(negedge clk);
    chk(req_ready == 1, "R11", "reset req_ready", 32'(req_ready), 1);
    chk(mem_valid == 0, "R11", "reset mem_valid", 32'(mem_valid), 0);
    chk(done == 0 && rdata == 0, "R11", "reset done/rdata", rdata, 0);
    rst_n = 1;
    for (int v = 0; v < NV; v++) run_op(V_SZ[v], V_AD[v], V_WR[v], V_WD[v], V_WT[v]);
    // reset during a multi-piece access
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = 2; req_addr = 32'd9;
    @(negedge clk);
    req_valid = 0;
    chk(mem_valid == 1, "R5", "access started", 32'(mem_valid), 1);
    rst_n = 0;
    #1;
    chk(mem_valid == 0 && req_ready == 1, "R11", "mid-access reset", 32'(mem_valid), 0);
    chk(rdata == 0 && done == 0, "R11", "mid-access reset data", rdata, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule